// File: doc/BRIEF.md
# External Bus Release Arbiter

This block hands the external bus over to an outside master and takes it back. The outside master requests the bus with an active-low input. That input is asynchronous, so it first passes through a synchronizer. The block answers with an active-low acknowledge. Before the acknowledge falls, the on-chip output-enable lanes for address, data and control drop low, which puts those pins into high impedance.

While the bus is handed over, on-chip requests for an external access and refresh requests are held back. If the takeback-enable setting is on, the block drives an active-low takeback output. This output asks the outside master to give the bus back.

The arbiter decides only at bus-cycle boundaries, which are signalled by a cycle-idle input. Priority runs in this order: refresh first, then the outside master's request, then an on-chip external access. Each refresh or access it grants appears as a one-cycle start pulse.

Top module: `xbus_release_arbiter`

## Requirements
- R1: When release_en is 0, a low on ext_req_n is ignored: ext_ack_n stays 1 and bus_oe stays all ones.
- R2: ext_req_n passes through SYNC_STAGES (default 2) flops before it is used. When the synchronized request is low, release_en is 1, cycle_idle is 1 and no refresh is requested, the hand-off begins at the next edge. ext_ack_n goes low one edge later.
- R3: bus_oe (one bit per lane, 1 = on-chip drivers enabled) goes to all zeros one cycle before ext_ack_n falls. It returns to all ones one cycle after ext_ack_n rises, so the two masters never drive the bus together.
- R4: While ext_ack_n is 0, access_start stays 0 even if int_ext_req is held high.
- R5: While ext_ack_n is 0, refresh_start stays 0 even if refresh_req is held high.
- R6: Once the synchronized request returns high, ext_ack_n goes high at the next edge.
- R7: takeback_n is 0 only while ext_ack_n is 0, takeback_en is 1, and int_ext_req or refresh_req is pending. It is 1 whenever takeback_en is 0, and it rises in the same cycle that ext_ack_n rises.
- R8: If a release request and int_ext_req are both present at the same cycle boundary, the release is taken and no access_start is issued.
- R9: If refresh_req and a release request are both present at the same cycle boundary, refresh_start pulses and the release waits.
- R10: When the released state ends with both refresh_req and int_ext_req pending, refresh_start is issued before access_start.
- R11: After reset, ext_ack_n=1, takeback_n=1, bus_oe is all ones, and both start pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| release_en | input | 1 | Allows the bus to be handed over |
| takeback_en | input | 1 | Allows the takeback output to be driven |
| ext_req_n | input | 1 | Asynchronous active-low request from the outside master |
| cycle_idle | input | 1 | High at a bus-cycle boundary |
| int_ext_req | input | 1 | On-chip master wants an external access |
| refresh_req | input | 1 | Refresh is requested |
| ext_ack_n | output | 1 | Active-low grant to the outside master |
| takeback_n | output | 1 | Active-low request for the bus to be returned |
| bus_oe | output | OE_LANES | On-chip output enables (address, data, control) |
| refresh_start | output | 1 | One-cycle grant of a refresh cycle |
| access_start | output | 1 | One-cycle grant of an on-chip external access |

## Verification
The handshake state is compared against a behavioural model on every clock. Because of this, a wrong state shows up at the ports within one cycle. A state that is stuck or skipped shows first on ext_ack_n or bus_oe. If the hand-off step is lost, both change in the same cycle. If the reclaim step is lost, bus_oe returns too early. A wrong priority order shows up as a start pulse at the wrong boundary, or as a release that happens when a refresh should have won. A takeback fault shows up as takeback_n low outside the grant, or high while work is pending.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  typedef enum logic [1:0] {
    XB_OWNED    = 2'd0,
    XB_HANDOFF  = 2'd1,
    XB_RELEASED = 2'd2,
    XB_RECLAIM  = 2'd3
  } xbr_state_e;

  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_REFRESH = 2'd1,
    PICK_RELEASE = 2'd2,
    PICK_ACCESS  = 2'd3
  } xbr_pick_e;
endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/xbr_arb.sv
module xbr_arb
  import xbr_pkg::*;
(
  input  xbr_state_e state,
  input  logic       cycle_idle,
  input  logic       refresh_req,
  input  logic       release_req,
  input  logic       access_req,
  output xbr_pick_e  pick
);
  always_comb begin
    pick = PICK_NONE;
    if (state == XB_OWNED && cycle_idle) begin
      if (refresh_req)      pick = PICK_REFRESH;
      else if (release_req) pick = PICK_RELEASE;
      else if (access_req)  pick = PICK_ACCESS;
    end
  end
endmodule

// File: rtl/xbr_fsm.sv
module xbr_fsm
  import xbr_pkg::*;
#(
  parameter int OE_LANES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_sync,
  input  logic                takeback_en,
  input  logic                pending,
  input  xbr_pick_e           pick,
  output xbr_state_e          state,
  output logic                ext_ack_n,
  output logic                takeback_n,
  output logic [OE_LANES-1:0] bus_oe,
  output logic                refresh_start,
  output logic                access_start
);
  xbr_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      XB_OWNED:    if (pick == PICK_RELEASE) nxt = XB_HANDOFF;
      XB_HANDOFF:  nxt = XB_RELEASED;
      XB_RELEASED: if (!req_sync) nxt = XB_RECLAIM;
      XB_RECLAIM:  nxt = XB_OWNED;
      default:     nxt = XB_OWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= XB_OWNED;
      ext_ack_n     <= 1'b1;
      takeback_n    <= 1'b1;
      bus_oe        <= {OE_LANES{1'b1}};
      refresh_start <= 1'b0;
      access_start  <= 1'b0;
    end else begin
      state         <= nxt;
      ext_ack_n     <= (nxt != XB_RELEASED);
      takeback_n    <= !(nxt == XB_RELEASED && takeback_en && pending);
      bus_oe        <= {OE_LANES{nxt == XB_OWNED}};
      refresh_start <= (pick == PICK_REFRESH);
      access_start  <= (pick == PICK_ACCESS);
    end
  end

  // R3
  oe_off_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_ack_n |-> (bus_oe == '0));
  // R3
  oe_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ack_n) |-> $past(bus_oe == '0));
  // R3
  oe_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_ack_n) |-> (bus_oe == '0));
  // R4
  no_start_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_ack_n |-> (!access_start && !refresh_start));
  // R7
  takeback_only_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !takeback_n |-> !ext_ack_n);
endmodule

// File: rtl/xbus_release_arbiter.sv
module xbus_release_arbiter
  import xbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OE_LANES    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                release_en,
  input  logic                takeback_en,
  input  logic                ext_req_n,
  input  logic                cycle_idle,
  input  logic                int_ext_req,
  input  logic                refresh_req,
  output logic                ext_ack_n,
  output logic                takeback_n,
  output logic [OE_LANES-1:0] bus_oe,
  output logic                refresh_start,
  output logic                access_start
);
  logic       req_n_sync;
  logic       req_sync;
  xbr_state_e state;
  xbr_pick_e  pick;

  xbr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_req_n),
    .dout (req_n_sync)
  );

  assign req_sync = !req_n_sync;

  xbr_arb u_arb (
    .state       (state),
    .cycle_idle  (cycle_idle),
    .refresh_req (refresh_req),
    .release_req (release_en && req_sync),
    .access_req  (int_ext_req),
    .pick        (pick)
  );

  xbr_fsm #(.OE_LANES(OE_LANES)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_sync      (req_sync),
    .takeback_en   (takeback_en),
    .pending       (int_ext_req || refresh_req),
    .pick          (pick),
    .state         (state),
    .ext_ack_n     (ext_ack_n),
    .takeback_n    (takeback_n),
    .bus_oe        (bus_oe),
    .refresh_start (refresh_start),
    .access_start  (access_start)
  );
endmodule

// File: tb/tb_xbus_release_arbiter.sv
module tb_xbus_release_arbiter;
  localparam int SYNC_STAGES = 2;
  localparam int OE_LANES    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic release_en = 1'b0, takeback_en = 1'b0, ext_req_n = 1'b1;
  logic cycle_idle = 1'b1, int_ext_req = 1'b0, refresh_req = 1'b0;
  logic ext_ack_n, takeback_n, refresh_start, access_start;
  logic [OE_LANES-1:0] bus_oe;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xbus_release_arbiter #(.SYNC_STAGES(SYNC_STAGES), .OE_LANES(OE_LANES)) dut (
    .clk(clk), .rst(rst), .release_en(release_en), .takeback_en(takeback_en),
    .ext_req_n(ext_req_n), .cycle_idle(cycle_idle), .int_ext_req(int_ext_req),
    .refresh_req(refresh_req), .ext_ack_n(ext_ack_n), .takeback_n(takeback_n),
    .bus_oe(bus_oe), .refresh_start(refresh_start), .access_start(access_start)
  );

  // Behavioural reference: queue for the synchronizer, integer phase
  bit q_req_n[$];
  int ph;            // 0 owned, 1 handing off, 2 granted, 3 giving back
  bit m_ack_n, m_tb_n, m_oe, m_rs, m_as;

  always @(posedge clk) begin
    if (rst) begin
      q_req_n = {};
      for (int i = 0; i < SYNC_STAGES; i++) q_req_n.push_back(1'b1);
      ph = 0; m_ack_n = 1; m_tb_n = 1; m_oe = 1; m_rs = 0; m_as = 0;
    end else begin
      bit want;
      int np;
      want = !q_req_n[0];
      np = ph; m_rs = 0; m_as = 0;
      if (ph == 0) begin
        if (cycle_idle) begin
          if (refresh_req) m_rs = 1;
          else if (release_en && want) np = 1;
          else if (int_ext_req) m_as = 1;
        end
      end else if (ph == 1) np = 2;
      else if (ph == 2) begin if (!want) np = 3; end
      else np = 0;
      ph = np;
      m_ack_n = (ph != 2);
      m_oe = (ph == 0);
      m_tb_n = !(ph == 2 && takeback_en && (int_ext_req || refresh_req));
      void'(q_req_n.pop_front());
      q_req_n.push_back(ext_req_n);
    end
  end

  task automatic chk(input string tag, input logic [OE_LANES-1:0] act, input logic [OE_LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  // One cycle: compare at negedge, then react to start pulses
  task automatic step();
    @(negedge clk);
    chk("R2/R6 ack", {{(OE_LANES-1){1'b0}}, ext_ack_n}, {{(OE_LANES-1){1'b0}}, m_ack_n});
    chk("R3 oe", bus_oe, {OE_LANES{m_oe}});
    chk("R7 takeback", {{(OE_LANES-1){1'b0}}, takeback_n}, {{(OE_LANES-1){1'b0}}, m_tb_n});
    chk("R5/R9/R10 refresh_start", {{(OE_LANES-1){1'b0}}, refresh_start}, {{(OE_LANES-1){1'b0}}, m_rs});
    chk("R4/R8 access_start", {{(OE_LANES-1){1'b0}}, access_start}, {{(OE_LANES-1){1'b0}}, m_as});
    if (refresh_start) refresh_req = 0;
    if (access_start) int_ext_req = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset values
    chk("R11 ack", {2'b0, ext_ack_n}, 3'b001);
    chk("R11 oe", bus_oe, {OE_LANES{1'b1}});
    chk("R11 takeback", {2'b0, takeback_n}, 3'b001);
    chk("R11 starts", {1'b0, refresh_start, access_start}, 3'b000);

    // R1 request ignored while disabled
    ext_req_n = 0; run(8);
    chk("R1 ack held high", {2'b0, ext_ack_n}, 3'b001);
    ext_req_n = 1; run(4);

    // R2 R3 R4 R5 R7 grant with pending work, takeback on
    release_en = 1; takeback_en = 1; ext_req_n = 0; run(6);
    chk("R2 granted", {2'b0, ext_ack_n}, 3'b000);
    int_ext_req = 1; run(3);
    refresh_req = 1; run(4);
    chk("R7 takeback low", {2'b0, takeback_n}, 3'b000);
    // R6 R10 give back with both pending
    ext_req_n = 1; run(10);
    chk("R10 both served", {1'b0, refresh_req, int_ext_req}, 3'b000);

    // R7 takeback disabled keeps output high
    takeback_en = 0; ext_req_n = 0; run(6);
    int_ext_req = 1; run(4);
    chk("R7 disabled high", {2'b0, takeback_n}, 3'b001);
    ext_req_n = 1; run(8);

    // R8 release beats access at same boundary
    takeback_en = 1; cycle_idle = 0; ext_req_n = 0; int_ext_req = 1; run(5);
    cycle_idle = 1; run(4);
    chk("R8 release taken", {2'b0, ext_ack_n}, 3'b000);
    ext_req_n = 1; run(8);

    // R9 refresh beats release at same boundary
    cycle_idle = 0; ext_req_n = 0; refresh_req = 1; run(5);
    cycle_idle = 1; run(1);
    chk("R9 refresh first", {2'b0, refresh_start}, 3'b001);
    run(6);
    ext_req_n = 1; run(8);

    // R2 no release while bus cycle busy
    cycle_idle = 0; ext_req_n = 0; run(8);
    chk("R2 waits for idle", {2'b0, ext_ack_n}, 3'b001);
    cycle_idle = 1; run(5);
    ext_req_n = 1; run(6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule